// File: doc/BRIEF.md
# Dual-Class Interrupt Controller

This block collects a bank of level-sensitive peripheral interrupt lines into a source register. Two software-written enable masks split each source into a normal class and a fast class. For each class the block keeps a pending vector that shows every active interrupt of that class at once. It raises a request line for each class. It also reports, in the same cycle, the bit number of the highest-priority pending interrupt of each class. Priority follows bit position, and the top bit wins.

When any request is active, the controller asserts an autovector line. It also presents a vector address formed from a programmable vector base plus a class offset. The fast class uses offset 0x2C and the normal class uses offset 0x28. Fast takes precedence when both classes are pending. Software reaches the masks, the base and the status vectors through a small synchronous register port, and read data is registered.

Top module: `irqc_top`

## Requirements
- R1: The source register is cleared by reset. At every clock edge it captures `irq_in`, so pending state follows the request lines one cycle later, with no latching. It reads back at address 0.
- R2: The normal enable mask (address 1), the fast enable mask (address 2) and the vector base (address 5) reset to zero. A write to one of these addresses changes it at the next clock edge. A read returns its current value on `reg_rdata` one clock after the address is presented.
- R3: The normal pending vector equals the source register AND the normal mask. The fast pending vector equals the source register AND the fast mask. A source enabled in both masks shows in both vectors, and a source enabled in neither shows in none. The two vectors read back at addresses 3 (normal) and 4 (fast).
- R4: When any fast pending bit is set, `fast_vld` is 1 and `fast_idx` is the number of the highest set bit of the fast pending vector. Bit 31 is the highest priority and bit 0 the lowest.
- R5: When any normal pending bit is set, `norm_vld` is 1 and `norm_idx` is the number of the highest set bit of the normal pending vector, with the same ordering as R4.
- R6: When a class has no pending bit, its valid flag is 0 and its index is 0.
- R7: `fast_req` is 1 exactly when some fast pending bit is set. `norm_req` is 1 exactly when some normal pending bit is set.
- R8: `avec_req` is 1 whenever either request is active. `vec_addr` is the vector base plus 0x2C while a fast request is active, the base plus 0x28 while only a normal request is active, and 0 when nothing is pending.
- R9: Writes to the read-only addresses 0, 3 and 4 change nothing. Reads of the unmapped addresses 6 and 7 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 32 | Level-sensitive peripheral request lines |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| norm_pend | output | 32 | Normal pending vector |
| fast_pend | output | 32 | Fast pending vector |
| norm_req | output | 1 | Normal class request |
| fast_req | output | 1 | Fast class request |
| norm_idx | output | 5 | Highest pending normal bit number |
| norm_vld | output | 1 | Normal index valid |
| fast_idx | output | 5 | Highest pending fast bit number |
| fast_vld | output | 1 | Fast index valid |
| avec_req | output | 1 | Autovector request |
| vec_addr | output | 32 | Autovector address |

## Verification
The hardest situation to reach is a single source enabled in both masks while other sources are enabled in only one class. In that state the two index outputs and the fast-over-normal vector choice all depend on the same bit. The stimulus reaches it by reprogramming the fast mask to overlap a normal-only bit while several request lines stay high. It then walks the request pattern so that the shared bit is first the highest-priority bit and then is outranked by bit 31. Boundary patterns drive the lowest source alone and all lines high with both masks cleared, which shows that disabled sources never become pending.

// File: rtl/irqc_pkg.sv
`timescale 1ns/1ps
package irqc_pkg;
   typedef enum logic [2:0] {
      SEL_SRC   = 3'd0,
      SEL_NEN   = 3'd1,
      SEL_FEN   = 3'd2,
      SEL_NPND  = 3'd3,
      SEL_FPND  = 3'd4,
      SEL_VBASE = 3'd5
   } reg_sel_e;

   localparam int unsigned FAST_VEC_OFS = 32'h2C;
   localparam int unsigned NORM_VEC_OFS = 32'h28;
endpackage

// File: rtl/irqc_ff1.sv
`timescale 1ns/1ps
module irqc_ff1 #(
   parameter int W     = 32,
   parameter int STYLE = 0
) (
   input  logic [W-1:0]         vec,
   output logic [$clog2(W)-1:0] idx,
   output logic                 vld
);
   localparam int IW = $clog2(W);
   localparam int H  = W / 2;

   generate
      if (STYLE == 0) begin : g_scan
         always_comb begin
            idx = '0;
            vld = 1'b0;
            for (int i = 0; i < W; i++) begin
               if (vec[i]) begin
                  idx = IW'(i);
                  vld = 1'b1;
               end
            end
         end
      end else begin : g_split
         if ((W & (W - 1)) != 0 || W < 4) begin : g_bad
            $error("irqc_ff1: split style needs a power-of-two width of at least 4");
         end
         logic [IW-2:0] up_idx, lo_idx;
         logic          up_vld, lo_vld;

         irqc_ff1 #(.W(H), .STYLE(0)) u_up (
            .vec(vec[W-1:H]), .idx(up_idx), .vld(up_vld)
         );
         irqc_ff1 #(.W(H), .STYLE(0)) u_lo (
            .vec(vec[H-1:0]), .idx(lo_idx), .vld(lo_vld)
         );

         always_comb begin
            vld = up_vld | lo_vld;
            idx = up_vld ? {1'b1, up_idx} : {1'b0, lo_idx};
         end
      end
   endgenerate
endmodule

// File: rtl/irqc_regs.sv
`timescale 1ns/1ps
module irqc_regs
   import irqc_pkg::*;
#(
   parameter int NUM_SRC = 32,
   parameter int DATA_W  = 32,
   parameter int REG_AW  = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] irq_in,
   input  logic               we,
   input  logic [REG_AW-1:0]  addr,
   input  logic [DATA_W-1:0]  wdata,
   input  logic [NUM_SRC-1:0] npend,
   input  logic [NUM_SRC-1:0] fpend,
   output logic [NUM_SRC-1:0] src_q,
   output logic [NUM_SRC-1:0] nen,
   output logic [NUM_SRC-1:0] fen,
   output logic [DATA_W-1:0]  vbase,
   output logic [DATA_W-1:0]  rdata
);
   logic [DATA_W-1:0] rd_mux;
   logic              sel_hi;
   reg_sel_e          sel;

   generate
      if (REG_AW > 3) begin : g_wide
         assign sel_hi = |addr[REG_AW-1:3];
      end else begin : g_narrow
         assign sel_hi = 1'b0;
      end
   endgenerate

   assign sel = reg_sel_e'(addr[2:0]);

   always_comb begin
      rd_mux = '0;
      if (!sel_hi) begin
         case (sel)
            SEL_SRC:   rd_mux = DATA_W'(src_q);
            SEL_NEN:   rd_mux = DATA_W'(nen);
            SEL_FEN:   rd_mux = DATA_W'(fen);
            SEL_NPND:  rd_mux = DATA_W'(npend);
            SEL_FPND:  rd_mux = DATA_W'(fpend);
            SEL_VBASE: rd_mux = vbase;
            default:   rd_mux = '0;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_q <= '0;
         nen   <= '0;
         fen   <= '0;
         vbase <= '0;
         rdata <= '0;
      end else begin
         src_q <= irq_in;
         rdata <= rd_mux;
         if (we && !sel_hi) begin
            case (sel)
               SEL_NEN:   nen   <= wdata[NUM_SRC-1:0];
               SEL_FEN:   fen   <= wdata[NUM_SRC-1:0];
               SEL_VBASE: vbase <= wdata;
               default:   ;
            endcase
         end
      end
   end
endmodule

// File: rtl/irqc_vec.sv
`timescale 1ns/1ps
module irqc_vec #(
   parameter int          NUM_SRC  = 32,
   parameter int          DATA_W   = 32,
   parameter int unsigned FAST_OFS = 32'h2C,
   parameter int unsigned NORM_OFS = 32'h28
) (
   input  logic [NUM_SRC-1:0] npend,
   input  logic [NUM_SRC-1:0] fpend,
   input  logic [DATA_W-1:0]  vbase,
   output logic               nreq,
   output logic               freq,
   output logic               avec,
   output logic [DATA_W-1:0]  vaddr
);
   always_comb begin
      freq  = |fpend;
      nreq  = |npend;
      avec  = freq | nreq;
      if (freq)
         vaddr = vbase + DATA_W'(FAST_OFS);
      else if (nreq)
         vaddr = vbase + DATA_W'(NORM_OFS);
      else
         vaddr = '0;
   end
endmodule

// File: rtl/irqc_top.sv
`timescale 1ns/1ps
module irqc_top
   import irqc_pkg::*;
#(
   parameter int          NUM_SRC   = 32,
   parameter int          DATA_W    = 32,
   parameter int          REG_AW    = 3,
   parameter int          FF1_STYLE = 1,
   parameter int unsigned FAST_OFS  = FAST_VEC_OFS,
   parameter int unsigned NORM_OFS  = NORM_VEC_OFS
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NUM_SRC-1:0]         irq_in,
   input  logic                       reg_we,
   input  logic [REG_AW-1:0]          reg_addr,
   input  logic [DATA_W-1:0]          reg_wdata,
   output logic [DATA_W-1:0]          reg_rdata,
   output logic [NUM_SRC-1:0]         norm_pend,
   output logic [NUM_SRC-1:0]         fast_pend,
   output logic                       norm_req,
   output logic                       fast_req,
   output logic [$clog2(NUM_SRC)-1:0] norm_idx,
   output logic                       norm_vld,
   output logic [$clog2(NUM_SRC)-1:0] fast_idx,
   output logic                       fast_vld,
   output logic                       avec_req,
   output logic [DATA_W-1:0]          vec_addr
);
   generate
      if (NUM_SRC < 4 || NUM_SRC > DATA_W) begin : g_bad_src
         $error("irqc_top: NUM_SRC must lie between 4 and DATA_W");
      end
      if (REG_AW < 3) begin : g_bad_aw
         $error("irqc_top: REG_AW must be at least 3");
      end
      if (FAST_OFS == NORM_OFS) begin : g_bad_ofs
         $error("irqc_top: class offsets must differ");
      end
   endgenerate

   logic [NUM_SRC-1:0] src_q, nen, fen;
   logic [DATA_W-1:0]  vbase;

   assign norm_pend = src_q & nen;
   assign fast_pend = src_q & fen;

   irqc_regs #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .REG_AW(REG_AW)) u_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .irq_in(irq_in),
      .we    (reg_we),
      .addr  (reg_addr),
      .wdata (reg_wdata),
      .npend (norm_pend),
      .fpend (fast_pend),
      .src_q (src_q),
      .nen   (nen),
      .fen   (fen),
      .vbase (vbase),
      .rdata (reg_rdata)
   );

   irqc_ff1 #(.W(NUM_SRC), .STYLE(FF1_STYLE)) u_ff1_fast (
      .vec(fast_pend), .idx(fast_idx), .vld(fast_vld)
   );

   irqc_ff1 #(.W(NUM_SRC), .STYLE(FF1_STYLE)) u_ff1_norm (
      .vec(norm_pend), .idx(norm_idx), .vld(norm_vld)
   );

   irqc_vec #(
      .NUM_SRC(NUM_SRC), .DATA_W(DATA_W),
      .FAST_OFS(FAST_OFS), .NORM_OFS(NORM_OFS)
   ) u_vec (
      .npend(norm_pend),
      .fpend(fast_pend),
      .vbase(vbase),
      .nreq (norm_req),
      .freq (fast_req),
      .avec (avec_req),
      .vaddr(vec_addr)
   );
endmodule

// File: rtl/irqc_top_chk.sv
`timescale 1ns/1ps
module irqc_top_chk #(
   parameter int          NUM_SRC  = 32,
   parameter int          DATA_W   = 32,
   parameter int unsigned FAST_OFS = 32'h2C,
   parameter int unsigned NORM_OFS = 32'h28
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic [NUM_SRC-1:0]         irq_in,
   input logic [NUM_SRC-1:0]         src_q,
   input logic [NUM_SRC-1:0]         nen,
   input logic [NUM_SRC-1:0]         fen,
   input logic [DATA_W-1:0]          vbase,
   input logic [NUM_SRC-1:0]         norm_pend,
   input logic [NUM_SRC-1:0]         fast_pend,
   input logic                       norm_req,
   input logic                       fast_req,
   input logic [$clog2(NUM_SRC)-1:0] norm_idx,
   input logic                       norm_vld,
   input logic [$clog2(NUM_SRC)-1:0] fast_idx,
   input logic                       fast_vld,
   input logic                       avec_req,
   input logic [DATA_W-1:0]          vec_addr
);
   assert_src_follow_R1: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> src_q == $past(irq_in));

   assert_pend_masked_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ((fast_pend & ~fen) == '0) && ((norm_pend & ~nen) == '0));

   assert_fast_top_R4: assert property (@(posedge clk) disable iff (!rst_n)
      fast_vld |-> (fast_pend >> fast_idx) == NUM_SRC'(1));

   assert_norm_top_R5: assert property (@(posedge clk) disable iff (!rst_n)
      norm_vld |-> (norm_pend >> norm_idx) == NUM_SRC'(1));

   assert_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !fast_vld |-> (fast_pend == '0) && (fast_idx == '0));

   assert_req_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (fast_req == fast_vld) && (norm_req == norm_vld));

   assert_fast_vec_R8: assert property (@(posedge clk) disable iff (!rst_n)
      fast_req |-> avec_req && (vec_addr == vbase + DATA_W'(FAST_OFS)));

   assert_norm_vec_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (norm_req && !fast_req) |-> avec_req && (vec_addr == vbase + DATA_W'(NORM_OFS)));
endmodule

bind irqc_top irqc_top_chk #(
   .NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .FAST_OFS(FAST_OFS), .NORM_OFS(NORM_OFS)
) u_chk (.*);

// File: tb/irqc_top_test.sv
`timescale 1ns/1ps
module irqc_top_test;
   localparam int N  = 32;
   localparam int DW = 32;

   typedef struct {
      string       tag;
      logic [31:0] fp, np, va, rd;
      logic [4:0]  fi, ni;
      logic        fv, nv, fr, nr, av, chk_rd;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  irq_in = '0;
   logic          reg_we = 1'b0;
   logic [2:0]    reg_addr = '0;
   logic [DW-1:0] reg_wdata = '0;
   logic [DW-1:0] reg_rdata, vec_addr;
   logic [N-1:0]  norm_pend, fast_pend;
   logic          norm_req, fast_req, norm_vld, fast_vld, avec_req;
   logic [4:0]    norm_idx, fast_idx;

   int   total = 0;
   int   bad = 0;
   bit   done = 1'b0;
   exp_t q[$];

   logic [31:0] m_src = '0, m_nen = '0, m_fen = '0, m_vb = '0;

   always #2.5 clk = ~clk;

   irqc_top uut (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_we(reg_we),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .norm_pend(norm_pend), .fast_pend(fast_pend), .norm_req(norm_req),
      .fast_req(fast_req), .norm_idx(norm_idx), .norm_vld(norm_vld),
      .fast_idx(fast_idx), .fast_vld(fast_vld), .avec_req(avec_req),
      .vec_addr(vec_addr)
   );

   function automatic logic [5:0] top_bit(input logic [31:0] v);
      for (int i = 31; i >= 0; i--)
         if (v[i]) return {1'b1, 5'(i)};
      return 6'd0;
   endfunction

   function automatic logic [31:0] model_read(input logic [2:0] a);
      case (a)
         3'd0:    return m_src;
         3'd1:    return m_nen;
         3'd2:    return m_fen;
         3'd3:    return m_src & m_nen;
         3'd4:    return m_src & m_fen;
         3'd5:    return m_vb;
         default: return 32'd0;
      endcase
   endfunction

   task automatic step(input logic [31:0] irq, input logic we, input logic [2:0] a,
                       input logic [31:0] wd, input string tag);
      exp_t e;
      logic [5:0] f, n;
      @(negedge clk);
      irq_in = irq; reg_we = we; reg_addr = a; reg_wdata = wd;
      e.rd = model_read(a);
      e.chk_rd = !we;
      if (we) begin
         case (a)
            3'd1: m_nen = wd;
            3'd2: m_fen = wd;
            3'd5: m_vb = wd;
            default: ;
         endcase
      end
      m_src = irq;
      e.tag = tag;
      e.fp = m_src & m_fen;
      e.np = m_src & m_nen;
      f = top_bit(e.fp);
      n = top_bit(e.np);
      e.fv = f[5]; e.fi = f[4:0];
      e.nv = n[5]; e.ni = n[4:0];
      e.fr = |e.fp; e.nr = |e.np;
      e.av = e.fr | e.nr;
      e.va = e.fr ? m_vb + 32'h2C : (e.nr ? m_vb + 32'h28 : 32'd0);
      q.push_back(e);
   endtask

   initial begin : monitor
      exp_t e;
      bit ok;
      forever begin
         @(posedge clk);
         #1;
         if (q.size() > 0) begin
            e = q.pop_front();
            ok = (fast_pend == e.fp) && (norm_pend == e.np) &&
                 (fast_idx == e.fi) && (fast_vld == e.fv) &&
                 (norm_idx == e.ni) && (norm_vld == e.nv) &&
                 (fast_req == e.fr) && (norm_req == e.nr) &&
                 (avec_req == e.av) && (vec_addr == e.va) &&
                 (!e.chk_rd || reg_rdata == e.rd);
            total++;
            if (!ok) begin
               bad++;
               $display("FAIL %s: act fp=%h np=%h fi=%0d/%b ni=%0d/%b req=%b%b av=%b va=%h rd=%h exp fp=%h np=%h fi=%0d/%b ni=%0d/%b req=%b%b av=%b va=%h rd=%h",
                  e.tag, fast_pend, norm_pend, fast_idx, fast_vld, norm_idx, norm_vld,
                  fast_req, norm_req, avec_req, vec_addr, reg_rdata,
                  e.fp, e.np, e.fi, e.fv, e.ni, e.nv, e.fr, e.nr, e.av, e.va, e.rd);
            end
         end
      end
   end

   initial begin : watchdog
      #100000;
      if (!done) begin
         done = 1'b1;
         bad++;
         total++;
         $display("FAIL watchdog: act=timeout exp=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : driver
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // reset state of every register (R2, R1)
      for (int a = 0; a < 8; a++) step(32'h0, 1'b0, 3'(a), 32'h0, "R2 reset value");
      // program masks and base (R2)
      step(32'h0, 1'b1, 3'd1, 32'h0000_FF00, "R2 write normal mask");
      step(32'h0, 1'b1, 3'd2, 32'h8000_0001, "R2 write fast mask");
      step(32'h0, 1'b1, 3'd5, 32'h1000_0000, "R2 write vector base");
      step(32'h0, 1'b0, 3'd1, 32'h0, "R2 read normal mask");
      step(32'h0, 1'b0, 3'd2, 32'h0, "R2 read fast mask");
      step(32'h0, 1'b0, 3'd5, 32'h0, "R2 read vector base");
      // normal only (R3 R5 R7 R8)
      step(32'h0000_0100, 1'b0, 3'd3, 32'h0, "R3 R5 R8 normal only bit8");
      step(32'h0000_8300, 1'b0, 3'd3, 32'h0, "R5 R7 normal top bit15");
      // fast beats normal (R4 R8)
      step(32'h8000_0101, 1'b0, 3'd0, 32'h0, "R4 R8 fast bit31 wins");
      step(32'h8000_0101, 1'b0, 3'd4, 32'h0, "R1 R3 read source and fast pending");
      step(32'h0000_0001, 1'b0, 3'd4, 32'h0, "R4 lowest source bit0");
      // shared source in both classes (R3)
      step(32'h0000_0001, 1'b1, 3'd2, 32'h0000_0101, "R3 widen fast mask");
      step(32'h0000_0300, 1'b0, 3'd3, 32'h0, "R3 bit8 in both classes");
      step(32'h8000_0300, 1'b1, 3'd2, 32'h8000_0101, "R3 R4 bit31 outranks shared bit8");
      step(32'h0000_0000, 1'b0, 3'd0, 32'h0, "R1 R6 lines released");
      // read-only and unmapped addresses (R9)
      step(32'h0, 1'b1, 3'd0, 32'hFFFF_FFFF, "R9 write to source");
      step(32'h0, 1'b1, 3'd3, 32'hFFFF_FFFF, "R9 write to normal pending");
      step(32'h0, 1'b1, 3'd4, 32'hFFFF_FFFF, "R9 write to fast pending");
      step(32'h0, 1'b0, 3'd0, 32'h0, "R9 source unchanged");
      step(32'h0, 1'b0, 3'd3, 32'h0, "R9 normal pending unchanged");
      step(32'h0, 1'b0, 3'd4, 32'h0, "R9 fast pending unchanged");
      step(32'h0, 1'b1, 3'd6, 32'hDEAD_BEEF, "R9 write unmapped");
      step(32'h0, 1'b0, 3'd6, 32'h0, "R9 read unmapped");
      step(32'h0, 1'b0, 3'd7, 32'h0, "R9 read unmapped high");
      step(32'h0, 1'b0, 3'd1, 32'h0, "R9 masks untouched");
      // all lines high, masks cleared (R6)
      step(32'h0, 1'b1, 3'd1, 32'h0, "R2 clear normal mask");
      step(32'h0, 1'b1, 3'd2, 32'h0, "R2 clear fast mask");
      step(32'hFFFF_FFFF, 1'b0, 3'd0, 32'h0, "R6 R3 all high no enables");
      step(32'hFFFF_FFFF, 1'b0, 3'd0, 32'h0, "R1 read all-high source");
      step(32'hFFFF_FFFF, 1'b1, 3'd1, 32'h7FFF_FFFE, "R5 R8 normal wide mask");
      step(32'hFFFF_FFFF, 1'b1, 3'd5, 32'h0000_4000, "R8 new base");
      step(32'h0, 1'b0, 3'd0, 32'h0, "R6 drain");
      step(32'h0, 1'b0, 3'd0, 32'h0, "R6 idle");
      repeat (3) @(negedge clk);
      if (!done) begin
         done = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule